// File: doc/BRIEF.md
# Floppy Subsystem Host Register Window

This block is the host-facing register file of a four-drive floppy disk controller. A host reaches it over a small 8-bit port bus: a select strobe, a write/read qualifier, a 3-bit port offset and separate write and read data. The window presents live subsystem status, the kind of result the command engine last produced, and the result byte itself. Through the same window the host supplies the 16-bit memory address of a command parameter block. Writing the upper half of that address also launches the command engine. A separate port resets the diskette subsystem.

The command engine behind the window drives four drive-ready lines, a 2-bit result kind, an error byte, a busy flag and a one-cycle completion request. The window keeps the interrupt flag that such a request sets. The host clears that flag by reading the result byte. Reads are combinational, so read data is valid in the same cycle as the read strobe. Writes and their side effects take hold at the clock edge that samples the strobe.

Top module: `fdc_host_regs`

## Requirements
- R1: Reading offset 0 returns status. Bit 0 is drive 0 ready, bit 1 is drive 1 ready, bit 2 is the interrupt flag, bit 3 is 1 (controller present), bit 4 is 1 (double-density controller present, default parameter), bit 5 is drive 2 ready, bit 6 is drive 3 ready, and bit 7 is 0.
- R2: Reading offset 1 returns the result kind in bits 1:0, with bits 7:2 at 0. The codes are 00 error, 10 ready status, and 01/11 reserved.
- R3: Writing offset 1 loads the write data into bits 7:0 of the parameter address, without a start pulse.
- R4: When the engine is not busy, writing offset 2 loads bits 15:8 of the parameter address. It also raises the start output for exactly one clock, in the cycle after the write.
- R5: Writing offset 2 while the engine is busy is ignored: the address high byte is unchanged and no start pulse occurs.
- R6: Reading offset 3 with result kind 00 returns the engine's error byte unchanged.
- R7: Reading offset 3 with result kind 10 returns bits 3:0 as 0, bit 4 drive 2 ready, bit 5 drive 3 ready, bit 6 drive 0 ready and bit 7 drive 1 ready. With kind 01 or 11 it returns 0x00.
- R8: Writing offset 7 raises the subsystem reset output for exactly one clock, in the cycle after the write. It also clears the interrupt flag.
- R9: An engine completion request sets the interrupt flag, which drives the interrupt output. A read of offset 3 clears it. If a request and a clearing read fall in the same cycle, the flag stays set.
- R10: Reads of offsets 2, 4, 5, 6 and 7 return 0x00. Writes to offsets 0, 3, 4, 5 and 6 change no output and no status bit.
- R11: After hardware reset, the parameter address is 0x0000, and the start, subsystem reset and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Port access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 3 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed, else 0 |
| drv_ready | input | 4 | Ready line per drive, index = drive number |
| eng_busy | input | 1 | Command engine busy |
| eng_kind | input | 2 | Result kind from the engine |
| eng_err | input | 8 | Error result byte from the engine |
| eng_irq_req | input | 1 | One-cycle completion request |
| pb_addr | output | 16 | Parameter block address |
| start_pulse | output | 1 | One-cycle command launch |
| subsys_rst | output | 1 | One-cycle diskette subsystem reset |
| irq | output | 1 | Interrupt flag to the host |

## Verification
The ready lines are driven with complementary patterns (0101, 1010) and with single-drive and all-drive patterns. These show that status and the ready-kind result byte each place every drive at its own bit, and they expose swapped drive positions in the two different packings. The error byte is read with 0xA5 and 0x5A, which catches stuck or exchanged bits. The launch is tried both idle and busy, which separates a gated start from an unconditional one. The interrupt flag is raised and then cleared three ways: by a lone read, by a read that collides with a new request, and by a subsystem reset. This shows the clear sources and the priority of a new request.

// File: rtl/fdc_host_pkg.sv
// Shared port offsets and result-kind codes for the floppy host window.
// Assumes an 8-port window; offsets are fixed by the host software map.
package fdc_host_pkg;
    localparam int OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_STATUS = 3'd0;
    localparam logic [OFS_W-1:0] OFS_KIND_PBLO = 3'd1;
    localparam logic [OFS_W-1:0] OFS_PBHI = 3'd2;
    localparam logic [OFS_W-1:0] OFS_RESULT = 3'd3;
    localparam logic [OFS_W-1:0] OFS_SUBRST = 3'd7;

    typedef enum logic [1:0] {
        KIND_ERROR = 2'b00,
        KIND_RSV1  = 2'b01,
        KIND_READY = 2'b10,
        KIND_RSV3  = 2'b11
    } res_kind_t;
endpackage

// File: rtl/fdc_pb_latch.sv
// Parameter block address latch and launch generator.
// Assumes write strobes last one cycle; a high-byte write while busy is dropped.
module fdc_pb_latch #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                busy,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] pb_addr,
    output logic                start_pulse
);
    localparam int AW = 2 * BYTE_W;

    logic launch;
    assign launch = wr_hi && !busy;

    // Load address halves and register the one-cycle launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_addr     <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= launch;
            if (wr_lo)
                pb_addr[BYTE_W-1:0] <= wdata;
            if (launch)
                pb_addr[AW-1:BYTE_W] <= wdata;
        end
    end

    assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(wr_hi) && !$past(busy)));
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !start_pulse);
    assert_hi_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pb_addr[AW-1:BYTE_W]));
endmodule

// File: rtl/fdc_irq_flag.sv
// Interrupt flip-flop: set by engine completion, cleared by result read or subsystem reset.
// Assumes a new request outranks a clear in the same cycle so no event is lost.
module fdc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_rd,
    input  logic clr_rst,
    output logic flag
);
    // Hold the flag; set wins over either clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_rd || clr_rst)
            flag <= 1'b0;
    end

    assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag);
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !set_req) |=> !flag);
    assert_irq_rst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rst && !set_req) |=> !flag);
endmodule

// File: rtl/fdc_rd_mux.sv
// Read data selection for the host window; purely combinational.
// Assumes four drives; unused and reserved cases read as zero.
module fdc_rd_mux
    import fdc_host_pkg::*;
#(
    parameter int  BYTE_W = 8,
    parameter int  N_DRV  = 4,
    parameter bit  HAS_DD = 1'b1
) (
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [N_DRV-1:0]  drv_ready,
    input  logic              irq_flag,
    input  res_kind_t         kind,
    input  logic [BYTE_W-1:0] err_byte,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] status_b;
    logic [BYTE_W-1:0] kind_b;
    logic [BYTE_W-1:0] result_b;

    // Assemble the status byte from live drive lines and the flag.
    always_comb begin
        status_b    = '0;
        status_b[0] = drv_ready[0];
        status_b[1] = drv_ready[1];
        status_b[2] = irq_flag;
        status_b[3] = 1'b1;
        status_b[4] = HAS_DD;
        status_b[5] = drv_ready[2];
        status_b[6] = drv_ready[3];
    end

    // Zero-extend the result kind.
    always_comb begin
        kind_b      = '0;
        kind_b[1:0] = kind;
    end

    // Pick the result byte according to the result kind.
    always_comb begin
        result_b = '0;
        case (kind)
            KIND_ERROR: result_b = err_byte;
            KIND_READY: begin
                result_b[4] = drv_ready[2];
                result_b[5] = drv_ready[3];
                result_b[6] = drv_ready[0];
                result_b[7] = drv_ready[1];
            end
            default: result_b = '0;
        endcase
    end

    // Route the selected byte onto the read bus.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (ofs)
                OFS_STATUS:    rdata = status_b;
                OFS_KIND_PBLO: rdata = kind_b;
                OFS_RESULT:    rdata = result_b;
                default:       rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fdc_host_regs.sv
// Top of the floppy host register window: decodes port accesses,
// latches the parameter address, launches the engine and keeps the interrupt flag.
// Assumes each host access is a one-cycle strobe.
module fdc_host_regs
    import fdc_host_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int N_DRV  = 4,
    parameter bit HAS_DD = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [2:0]          bus_ofs,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [N_DRV-1:0]    drv_ready,
    input  logic                eng_busy,
    input  logic [1:0]          eng_kind,
    input  logic [BYTE_W-1:0]   eng_err,
    input  logic                eng_irq_req,
    output logic [2*BYTE_W-1:0] pb_addr,
    output logic                start_pulse,
    output logic                subsys_rst,
    output logic                irq
);
    logic wr_en, rd_en;
    logic wr_lo, wr_hi, wr_rst, rd_result;

    assign wr_en     = bus_sel && bus_wr;
    assign rd_en     = bus_sel && !bus_wr;
    assign wr_lo     = wr_en && (bus_ofs == OFS_KIND_PBLO);
    assign wr_hi     = wr_en && (bus_ofs == OFS_PBHI);
    assign wr_rst    = wr_en && (bus_ofs == OFS_SUBRST);
    assign rd_result = rd_en && (bus_ofs == OFS_RESULT);

    // Register the one-cycle subsystem reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            subsys_rst <= 1'b0;
        else
            subsys_rst <= wr_rst;
    end

    fdc_pb_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .busy        (eng_busy),
        .wdata       (bus_wdata),
        .pb_addr     (pb_addr),
        .start_pulse (start_pulse)
    );

    fdc_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (eng_irq_req),
        .clr_rd  (rd_result),
        .clr_rst (wr_rst),
        .flag    (irq)
    );

    fdc_rd_mux #(.BYTE_W(BYTE_W), .N_DRV(N_DRV), .HAS_DD(HAS_DD)) u_mux (
        .rd_en     (rd_en),
        .ofs       (bus_ofs),
        .drv_ready (drv_ready),
        .irq_flag  (irq),
        .kind      (res_kind_t'(eng_kind)),
        .err_byte  (eng_err),
        .rdata     (bus_rdata)
    );

    assert_subrst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        subsys_rst |-> ($past(bus_sel) && $past(bus_wr) && ($past(bus_ofs) == OFS_SUBRST)));
    assert_status_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_ofs == OFS_STATUS) |-> !bus_rdata[BYTE_W-1]);
    assert_status_irq_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_ofs == OFS_STATUS) |-> (bus_rdata[2] == irq));
    assert_unused_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_ofs != OFS_STATUS && bus_ofs != OFS_KIND_PBLO && bus_ofs != OFS_RESULT)
        |-> (bus_rdata == '0));
endmodule

// File: tb/fdc_host_regs_bench.sv
`timescale 1ns/1ps
module fdc_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_ofs = 3'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [3:0]  drv_ready = 4'h0;
    logic        eng_busy = 1'b0;
    logic [1:0]  eng_kind = 2'b00;
    logic [7:0]  eng_err = 8'h00;
    logic        eng_irq_req = 1'b0;
    logic [15:0] pb_addr;
    logic        start_pulse, subsys_rst, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fdc_host_regs u_fdc_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drv_ready(drv_ready), .eng_busy(eng_busy), .eng_kind(eng_kind),
        .eng_err(eng_err), .eng_irq_req(eng_irq_req), .pb_addr(pb_addr),
        .start_pulse(start_pulse), .subsys_rst(subsys_rst), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] ofs, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = ofs;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic irq_event();
        @(negedge clk); eng_irq_req = 1'b1;
        @(negedge clk); eng_irq_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 addr", pb_addr, 16'h0000);
        chk("R11 start", {15'd0, start_pulse}, 16'h0);
        chk("R11 subrst", {15'd0, subsys_rst}, 16'h0);
        chk("R11 irq", {15'd0, irq}, 16'h0);
        bus_read(3'd0, d);
        chk("R1 idle status", {8'h0, d}, 16'h0018);
    endtask

    task automatic t_status();
        logic [7:0] d;
        drv_ready = 4'b0101;
        bus_read(3'd0, d);
        chk("R1 status 0101", {8'h0, d}, 16'h0039);
        drv_ready = 4'b1010;
        bus_read(3'd0, d);
        chk("R1 status 1010", {8'h0, d}, 16'h005A);
        irq_event();
        bus_read(3'd0, d);
        chk("R1 status irq", {8'h0, d}, 16'h005E);
    endtask

    task automatic t_kind();
        logic [7:0] d;
        for (int k = 0; k < 4; k++) begin
            eng_kind = k[1:0];
            bus_read(3'd1, d);
            chk("R2 kind", {8'h0, d}, 16'(k));
        end
    endtask

    task automatic t_addr();
        bus_write(3'd1, 8'h34);
        chk("R3 low byte", pb_addr, 16'h0034);
        chk("R3 no start", {15'd0, start_pulse}, 16'h0);
        bus_write(3'd2, 8'h12);
        chk("R4 high byte", pb_addr, 16'h1234);
        chk("R4 start high", {15'd0, start_pulse}, 16'h1);
        @(negedge clk);
        chk("R4 start one cycle", {15'd0, start_pulse}, 16'h0);
    endtask

    task automatic t_busy();
        eng_busy = 1'b1;
        bus_write(3'd2, 8'hAB);
        chk("R5 busy addr", pb_addr, 16'h1234);
        chk("R5 busy no start", {15'd0, start_pulse}, 16'h0);
        @(negedge clk);
        chk("R5 busy no start later", {15'd0, start_pulse}, 16'h0);
        eng_busy = 1'b0;
    endtask

    task automatic t_err();
        logic [7:0] d;
        eng_kind = 2'b00;
        eng_err = 8'hA5;
        bus_read(3'd3, d);
        chk("R6 err A5", {8'h0, d}, 16'h00A5);
        eng_err = 8'h5A;
        bus_read(3'd3, d);
        chk("R6 err 5A", {8'h0, d}, 16'h005A);
    endtask

    task automatic t_ready();
        logic [7:0] d;
        eng_kind = 2'b10;
        drv_ready = 4'b0001;
        bus_read(3'd3, d);
        chk("R7 ready d0", {8'h0, d}, 16'h0040);
        drv_ready = 4'b0110;
        bus_read(3'd3, d);
        chk("R7 ready d1d2", {8'h0, d}, 16'h0090);
        drv_ready = 4'b1000;
        bus_read(3'd3, d);
        chk("R7 ready d3", {8'h0, d}, 16'h0020);
        drv_ready = 4'b1111;
        eng_kind = 2'b01;
        bus_read(3'd3, d);
        chk("R7 reserved 01", {8'h0, d}, 16'h0000);
        eng_kind = 2'b11;
        bus_read(3'd3, d);
        chk("R7 reserved 11", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        irq_event();
        chk("R9 irq set", {15'd0, irq}, 16'h1);
        bus_read(3'd3, d);
        chk("R9 read clears", {15'd0, irq}, 16'h0);
        irq_event();
        @(negedge clk);
        eng_irq_req = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = 3'd3;
        @(negedge clk);
        eng_irq_req = 1'b0; bus_sel = 1'b0;
        chk("R9 set wins", {15'd0, irq}, 16'h1);
        bus_read(3'd3, d);
        chk("R9 cleared again", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_subrst();
        logic [7:0] d;
        drv_ready = 4'b0000;
        irq_event();
        bus_write(3'd7, 8'h00);
        chk("R8 subrst high", {15'd0, subsys_rst}, 16'h1);
        chk("R8 irq cleared", {15'd0, irq}, 16'h0);
        @(negedge clk);
        chk("R8 subrst one cycle", {15'd0, subsys_rst}, 16'h0);
        bus_read(3'd0, d);
        chk("R8 status after", {8'h0, d}, 16'h0018);
    endtask

    task automatic t_unused();
        logic [7:0] d;
        logic [2:0] rlist [5] = '{3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
        logic [2:0] wlist [5] = '{3'd0, 3'd3, 3'd4, 3'd5, 3'd6};
        drv_ready = 4'b1111;
        for (int i = 0; i < 5; i++) begin
            bus_read(rlist[i], d);
            chk("R10 unused read", {8'h0, d}, 16'h0000);
        end
        for (int i = 0; i < 5; i++) begin
            bus_write(wlist[i], 8'hFF);
            chk("R10 ignored write addr", pb_addr, 16'h1234);
            chk("R10 ignored write pulses", {14'd0, start_pulse, subsys_rst}, 16'h0);
        end
        bus_read(3'd0, d);
        chk("R10 status intact", {7'h0, irq, d}, 16'h007B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_kind();
        t_addr();
        t_busy();
        t_err();
        t_ready();
        t_irq();
        t_subrst();
        t_unused();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule